// File: doc/BRIEF.md
# Command Stream Opcode Parser

This block sits on a stream of 32-bit command words and tells, for every word, whether it opens a new command (a header) or belongs to the payload of the one in progress. A header is classified by its top nibble, its fields are decoded, and the parser works out how many payload words follow. For writes whose payload length comes from a bit mask, the length is the population count of that mask. Each payload word is then tagged with the register offset it will land on, a write enable, and a flag on the last word of its command.

The block does not buffer. The output record is formed in the same cycle as the input word, and the input handshake is simply passed through to the output side. Commands that jump elsewhere in memory, or that take or release locks, are not executed. For those, the decoded address or fields are shown on the header word.

Top module: `cmd_parser`

## Requirements
- R1: The opcode is bits 31:28 of a header, shown on `out_opcode`. Codes 0, 1, 2, 3, 4, 5, 6 and 14 are known. Any other code raises `out_unknown` on that header and has no payload, so the next word is a header.
- R2: Opcode 0 (set class) loads the class from bits 15:6. That class shows on `out_class` from this header onward, and reset sets it to 0. Bits 5:0 form a mask: one payload word follows per set bit, each aimed at header offset (bits 27:16) plus the bit position, in ascending order. A zero mask gives no payload.
- R3: Opcode 1 (stepping write) has its payload count in bits 15:0. The n-th payload word (n from 0) targets offset bits 27:16 plus n. A zero count gives no payload.
- R4: Opcode 2 (fixed write) has its payload count in bits 15:0, and every payload word targets the header offset.
- R5: Opcode 3 (masked write) has a 16-bit mask in bits 15:0. One payload word follows per set bit, aimed at the header offset plus the bit position, lowest bit first.
- R6: Opcode 4 (immediate) has no payload and shows bits 15:0 on `out_imm_data`.
- R7: Opcode 5 (restart) has no payload. `out_jump_addr` shows the header shifted left by 4, keeping the low 32 bits.
- R8: Opcode 6 (gather) shows bit 15 on `out_gth_insert`, bit 14 on `out_gth_type` and bits 13:0 on `out_gth_count`. Exactly one payload word follows. That word has `out_wen` low and `out_last` high.
- R9: Opcode 14 (extend) has no payload and shows bits 7:0 on `out_lock_idx`. Sub-code bits 27:24 equal to 0 raise `out_lock_take`, and 1 raises `out_lock_drop`. Any other sub-code raises neither.
- R10: Headers have `out_is_hdr` high with `out_wen` and `out_last` low. On a header, `out_offset` is bits 27:16. `out_last` is high only on the final payload word of a command, and the word after it is a header.
- R11: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A word is consumed only when both are high, and otherwise the parser state holds.
- R12: Reset returns the parser to header state, even in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word may be taken |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Downstream accepts record |
| out_is_hdr | output | 1 | Current word is a header |
| out_opcode | output | 4 | Opcode of the command the word belongs to |
| out_class | output | 10 | Active class |
| out_offset | output | 12 | Header offset field or payload target offset |
| out_wen | output | 1 | Payload word is a register write |
| out_last | output | 1 | Final payload word of its command |
| out_unknown | output | 1 | Header with an unlisted opcode |
| out_imm_data | output | 16 | Immediate data |
| out_jump_addr | output | 32 | Restart byte address |
| out_gth_insert | output | 1 | Gather insert flag |
| out_gth_type | output | 1 | Gather type flag |
| out_gth_count | output | 14 | Gather word count |
| out_lock_take | output | 1 | Extend: acquire lock |
| out_lock_drop | output | 1 | Extend: release lock |
| out_lock_idx | output | 8 | Extend: lock index |

## Verification
The properties assume that the stream is framed correctly from reset: the first word after reset is a header, and nothing is inserted between a header and its payload. They also assume that a word presented with `in_valid` stays meaningful only in the cycle it is consumed. The stimulus keeps to these assumptions. Every command in the table is followed by exactly as many words as its header announces. The stall tests hold `in_valid` and `in_word` steady until the word is consumed. The mid-command reset is the only place where framing is broken, and the properties are disabled while reset is high.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int WORD_W     = 32;
    localparam int OP_W       = 4;
    localparam int OFF_W      = 12;
    localparam int CLS_W      = 10;
    localparam int MASK_W     = 16;
    localparam int SCL_MASK_W = 6;
    localparam int CNT_W      = 16;
    localparam int GCNT_W     = 14;
    localparam int LIDX_W     = 8;

    localparam logic [OP_W-1:0] OP_SETCL   = 4'd0;
    localparam logic [OP_W-1:0] OP_STEP    = 4'd1;
    localparam logic [OP_W-1:0] OP_FIXED   = 4'd2;
    localparam logic [OP_W-1:0] OP_MASKW   = 4'd3;
    localparam logic [OP_W-1:0] OP_IMM     = 4'd4;
    localparam logic [OP_W-1:0] OP_RESTART = 4'd5;
    localparam logic [OP_W-1:0] OP_GATHER  = 4'd6;
    localparam logic [OP_W-1:0] OP_EXT     = 4'd14;

    // how payload words pick their target offset
    typedef enum logic [1:0] {
        WALK_STEP = 2'd0,
        WALK_HOLD = 2'd1,
        WALK_MASK = 2'd2,
        WALK_ADDR = 2'd3
    } walk_e;

    typedef struct packed {
        logic                  known;
        walk_e                 walk;
        logic [CNT_W-1:0]      count;
        logic [OFF_W-1:0]      off;
        logic                  setcl;
        logic [CLS_W-1:0]      cls;
        logic [MASK_W-1:0]     mask;
        logic [15:0]           imm;
        logic [WORD_W-1:0]     jump;
        logic                  g_ins;
        logic                  g_typ;
        logic [GCNT_W-1:0]     g_cnt;
        logic                  lk_take;
        logic                  lk_drop;
        logic [LIDX_W-1:0]     lk_idx;
    } hdr_t;

    function automatic logic [CNT_W-1:0] ones_in(input logic [MASK_W-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) begin
            n = n + CNT_W'(m[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);

    logic [OP_W-1:0] op;
    assign op = word[31:28];

    always_comb begin
        hdr       = '0;
        hdr.known = 1'b1;
        hdr.walk  = WALK_HOLD;
        hdr.off   = word[27:16];
        case (op)
            OP_SETCL: begin
                hdr.setcl = 1'b1;
                hdr.cls   = word[15:6];
                hdr.mask  = {{(MASK_W-SCL_MASK_W){1'b0}}, word[SCL_MASK_W-1:0]};
                hdr.count = ones_in({{(MASK_W-SCL_MASK_W){1'b0}}, word[SCL_MASK_W-1:0]});
                hdr.walk  = WALK_MASK;
            end
            OP_STEP: begin
                hdr.count = word[15:0];
                hdr.walk  = WALK_STEP;
            end
            OP_FIXED: begin
                hdr.count = word[15:0];
                hdr.walk  = WALK_HOLD;
            end
            OP_MASKW: begin
                hdr.mask  = word[15:0];
                hdr.count = ones_in(word[15:0]);
                hdr.walk  = WALK_MASK;
            end
            OP_IMM: begin
                hdr.imm = word[15:0];
            end
            OP_RESTART: begin
                hdr.jump = {word[WORD_W-5:0], 4'b0000};
            end
            OP_GATHER: begin
                hdr.g_ins = word[15];
                hdr.g_typ = word[14];
                hdr.g_cnt = word[GCNT_W-1:0];
                hdr.count = CNT_W'(1);
                hdr.walk  = WALK_ADDR;
            end
            OP_EXT: begin
                hdr.lk_idx  = word[LIDX_W-1:0];
                hdr.lk_take = (word[27:24] == 4'd0);
                hdr.lk_drop = (word[27:24] == 4'd1);
            end
            default: begin
                hdr.known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cmd_mask_walk.sv
module cmd_mask_walk #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  hot,
    output logic [IW-1:0] idx
);

    always_comb begin
        logic seen;
        seen = 1'b0;
        hot  = '0;
        idx  = '0;
        for (int i = 0; i < W; i++) begin
            if (mask[i] && !seen) begin
                hot[i] = 1'b1;
                idx    = IW'(i);
            end
            seen = seen | mask[i];
        end
    end

endmodule

// File: rtl/cmd_frame_track.sv
module cmd_frame_track
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  hdr_t              hdr,
    input  logic [OP_W-1:0]   op_in,
    input  logic [MASK_W-1:0] step_hot,
    output logic              in_hdr,
    output logic              at_last,
    output walk_e             walk,
    output logic [OFF_W-1:0]  cur_off,
    output logic [MASK_W-1:0] mask_rem,
    output logic [OP_W-1:0]   cur_op,
    output logic [CLS_W-1:0]  cls
);

    logic [CNT_W-1:0] rem_q;

    assign in_hdr  = (rem_q == '0);
    assign at_last = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            walk     <= WALK_STEP;
            cur_off  <= '0;
            mask_rem <= '0;
            cur_op   <= '0;
            cls      <= '0;
        end else if (take) begin
            if (in_hdr) begin
                rem_q    <= hdr.count;
                walk     <= hdr.walk;
                cur_off  <= hdr.off;
                mask_rem <= hdr.mask;
                cur_op   <= op_in;
                if (hdr.setcl) begin
                    cls <= hdr.cls;
                end
            end else begin
                rem_q <= rem_q - CNT_W'(1);
                if (walk == WALK_STEP) begin
                    cur_off <= cur_off + OFF_W'(1);
                end
                if (walk == WALK_MASK) begin
                    mask_rem <= mask_rem & ~step_hot;
                end
            end
        end
    end

endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmdp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_is_hdr,
    output logic [OP_W-1:0]    out_opcode,
    output logic [CLS_W-1:0]   out_class,
    output logic [OFF_W-1:0]   out_offset,
    output logic               out_wen,
    output logic               out_last,
    output logic               out_unknown,
    output logic [15:0]        out_imm_data,
    output logic [WORD_W-1:0]  out_jump_addr,
    output logic               out_gth_insert,
    output logic               out_gth_type,
    output logic [GCNT_W-1:0]  out_gth_count,
    output logic               out_lock_take,
    output logic               out_lock_drop,
    output logic [LIDX_W-1:0]  out_lock_idx
);

    localparam int IW = $clog2(MASK_W);

    hdr_t              hdr;
    logic              take;
    logic              in_hdr;
    logic              at_last;
    walk_e             walk;
    logic [OFF_W-1:0]  cur_off;
    logic [MASK_W-1:0] mask_rem;
    logic [OP_W-1:0]   cur_op;
    logic [CLS_W-1:0]  cls_q;
    logic [MASK_W-1:0] step_hot;
    logic [IW-1:0]     step_idx;
    logic [OFF_W-1:0]  pay_off;

    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign take      = in_valid && out_ready;

    cmd_hdr_decode i_dec (
        .word (in_word),
        .hdr  (hdr)
    );

    cmd_mask_walk #(.W(MASK_W)) i_walk (
        .mask (mask_rem),
        .hot  (step_hot),
        .idx  (step_idx)
    );

    cmd_frame_track i_track (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .hdr      (hdr),
        .op_in    (in_word[31:28]),
        .step_hot (step_hot),
        .in_hdr   (in_hdr),
        .at_last  (at_last),
        .walk     (walk),
        .cur_off  (cur_off),
        .mask_rem (mask_rem),
        .cur_op   (cur_op),
        .cls      (cls_q)
    );

    assign pay_off = (walk == WALK_MASK) ? cur_off + OFF_W'(step_idx) : cur_off;

    always_comb begin
        out_is_hdr     = in_hdr;
        out_opcode     = in_hdr ? in_word[31:28] : cur_op;
        out_class      = (in_hdr && hdr.setcl) ? hdr.cls : cls_q;
        out_offset     = in_hdr ? hdr.off : pay_off;
        out_wen        = !in_hdr && (walk != WALK_ADDR);
        out_last       = !in_hdr && at_last;
        out_unknown    = in_hdr && !hdr.known;
        out_imm_data   = in_hdr ? hdr.imm : '0;
        out_jump_addr  = in_hdr ? hdr.jump : '0;
        out_gth_insert = in_hdr && hdr.g_ins;
        out_gth_type   = in_hdr && hdr.g_typ;
        out_gth_count  = in_hdr ? hdr.g_cnt : '0;
        out_lock_take  = in_hdr && hdr.lk_take;
        out_lock_drop  = in_hdr && hdr.lk_drop;
        out_lock_idx   = in_hdr ? hdr.lk_idx : '0;
    end

endmodule

// File: rtl/cmd_parser_chk.sv
module cmd_parser_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_ready,
    input logic        out_valid,
    input logic        out_is_hdr,
    input logic [3:0]  out_opcode,
    input logic [11:0] out_offset,
    input logic        out_wen,
    input logic        out_last
);

    logic acc;
    assign acc = out_valid && out_ready;

    // R10
    last_on_payload_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> !out_is_hdr);

    // R10
    wen_on_payload_chk: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> !out_is_hdr);

    // R10
    hdr_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && out_last) |=> out_is_hdr);

    // R6
    imm_no_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && out_is_hdr && out_opcode == 4'd4) |=> out_is_hdr);

    // R7
    restart_no_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && out_is_hdr && out_opcode == 4'd5) |=> out_is_hdr);

    // R9
    extend_no_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && out_is_hdr && out_opcode == 4'd14) |=> out_is_hdr);

    // R8
    gather_one_word_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && out_is_hdr && out_opcode == 4'd6) |=> (!out_is_hdr && out_last && !out_wen));

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(out_is_hdr));

    // R4
    fixed_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !out_is_hdr && out_opcode == 4'd2 && !out_last) |=> (out_offset == $past(out_offset)));

    // R3
    step_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !out_is_hdr && out_opcode == 4'd1 && !out_last) |=> (out_offset == $past(out_offset) + 12'd1));

    // R12
    reset_to_hdr_chk: assert property (@(posedge clk)
        rst |=> out_is_hdr);

endmodule

bind cmd_parser cmd_parser_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_is_hdr (out_is_hdr),
    .out_opcode (out_opcode),
    .out_offset (out_offset),
    .out_wen    (out_wen),
    .out_last   (out_last)
);

// File: tb/test_cmd_parser.sv
module test_cmd_parser;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_is_hdr;
    logic [3:0]  out_opcode;
    logic [9:0]  out_class;
    logic [11:0] out_offset;
    logic        out_wen;
    logic        out_last;
    logic        out_unknown;
    logic [15:0] out_imm_data;
    logic [31:0] out_jump_addr;
    logic        out_gth_insert;
    logic        out_gth_type;
    logic [13:0] out_gth_count;
    logic        out_lock_take;
    logic        out_lock_drop;
    logic [7:0]  out_lock_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cmd_parser i_cmd_parser (.*);

    // {word, is_hdr, opcode, offset, wen, last}
    localparam int NV = 22;
    localparam logic [50:0] VEC [NV] = '{
        // R3 stepping write, 3 words from 0x100
        {32'h1100_0003, 1'b1, 4'h1, 12'h100, 1'b0, 1'b0},
        {32'hAAAA_0001, 1'b0, 4'h1, 12'h100, 1'b1, 1'b0},
        {32'hAAAA_0002, 1'b0, 4'h1, 12'h101, 1'b1, 1'b0},
        {32'hAAAA_0003, 1'b0, 4'h1, 12'h102, 1'b1, 1'b1},
        // R4 fixed write
        {32'h2020_0002, 1'b1, 4'h2, 12'h020, 1'b0, 1'b0},
        {32'h1111_1111, 1'b0, 4'h2, 12'h020, 1'b1, 1'b0},
        {32'h2222_2222, 1'b0, 4'h2, 12'h020, 1'b1, 1'b1},
        // R5 masked write, mask 0x8005
        {32'h3040_8005, 1'b1, 4'h3, 12'h040, 1'b0, 1'b0},
        {32'h0000_0000, 1'b0, 4'h3, 12'h040, 1'b1, 1'b0},
        {32'hFFFF_FFFF, 1'b0, 4'h3, 12'h042, 1'b1, 1'b0},
        {32'h5A5A_5A5A, 1'b0, 4'h3, 12'h04F, 1'b1, 1'b1},
        // R2 set class 0x12, mask 0x0A
        {32'h0010_048A, 1'b1, 4'h0, 12'h010, 1'b0, 1'b0},
        {32'h0BAD_0001, 1'b0, 4'h0, 12'h011, 1'b1, 1'b0},
        {32'h0BAD_0002, 1'b0, 4'h0, 12'h013, 1'b1, 1'b1},
        // R6 immediate
        {32'h4055_BEEF, 1'b1, 4'h4, 12'h055, 1'b0, 1'b0},
        // R8 gather plus its address word
        {32'h6077_C123, 1'b1, 4'h6, 12'h077, 1'b0, 1'b0},
        {32'h8000_1000, 1'b0, 4'h6, 12'h077, 1'b0, 1'b1},
        // R9 extend
        {32'hE000_0005, 1'b1, 4'hE, 12'h000, 1'b0, 1'b0},
        // R1 unknown opcode 9
        {32'h9123_4567, 1'b1, 4'h9, 12'h123, 1'b0, 1'b0},
        // R2 set class with zero mask
        {32'h0000_0040, 1'b1, 4'h0, 12'h000, 1'b0, 1'b0},
        // R3 stepping write with zero count
        {32'h1300_0000, 1'b1, 4'h1, 12'h300, 1'b0, 1'b0},
        // R7 restart
        {32'h5000_0012, 1'b1, 4'h5, 12'h000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic present(input logic [31:0] w);
        @(negedge clk);
        in_word   = w;
        in_valid  = 1'b1;
        out_ready = 1'b1;
        #1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        chk("R12 hdr after reset", {31'b0, out_is_hdr}, 32'd1);
        chk("R12 class after reset", {22'b0, out_class}, 32'd0);
        chk("R11 ready follows", {31'b0, in_ready}, 32'd0);

        // table: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            present(VEC[i][50:19]);
            chk($sformatf("R10 table entry %0d", i),
                {13'b0, out_is_hdr, out_opcode, out_offset, out_wen, out_last},
                {13'b0, VEC[i][18:0]});
        end

        // R2 class persists; R6 data
        present(32'h4055_BEEF);
        chk("R2 class kept", {22'b0, out_class}, 32'h001);
        chk("R6 imm data", {16'b0, out_imm_data}, 32'h0000_BEEF);

        // R7 jump address
        present(32'h5ABC_DEF1);
        chk("R7 jump addr", out_jump_addr, 32'hABCD_EF10);

        // R8 gather fields
        present(32'h6077_C123);
        chk("R8 gather fields", {16'b0, out_gth_insert, out_gth_type, out_gth_count},
            {16'b0, 1'b1, 1'b1, 14'h0123});
        present(32'h0000_0000);
        chk("R8 gather payload", {29'b0, out_is_hdr, out_wen, out_last}, 32'b001);

        // R9 extend sub-codes
        present(32'hE100_00AB);
        chk("R9 release", {22'b0, out_lock_take, out_lock_drop, out_lock_idx}, {22'b0, 2'b01, 8'hAB});
        present(32'hE000_0007);
        chk("R9 acquire", {22'b0, out_lock_take, out_lock_drop, out_lock_idx}, {22'b0, 2'b10, 8'h07});
        present(32'hE700_0001);
        chk("R9 other sub", {30'b0, out_lock_take, out_lock_drop}, 32'd0);

        // R1 unknown flag
        present(32'hF000_0000);
        chk("R1 unknown 15", {31'b0, out_unknown}, 32'd1);
        present(32'h1000_0000);
        chk("R1 known step", {31'b0, out_unknown}, 32'd0);

        // R2 set class mask 0x21, class 0x3FF
        present(32'h0200_FFE1);
        chk("R2 class on hdr", {22'b0, out_class}, 32'h3FF);
        present(32'h0000_0001);
        chk("R2 first slot", {19'b0, out_offset, out_last}, {19'b0, 12'h200, 1'b0});
        present(32'h0000_0002);
        chk("R2 second slot", {19'b0, out_offset, out_last}, {19'b0, 12'h205, 1'b1});

        // R5 full mask: 16 words
        present(32'h3FF0_FFFF);
        for (int k = 0; k < 16; k++) begin
            present(32'h0000_0000 + k);
            chk($sformatf("R5 full mask word %0d", k), {19'b0, out_offset, out_last},
                {19'b0, 12'hFF0 + 12'(k), (k == 15)});
        end
        present(32'h4000_0000);
        chk("R10 hdr after mask", {31'b0, out_is_hdr}, 32'd1);

        // R11 stall: header held with ready low
        @(negedge clk);
        in_word   = 32'h1010_0002;
        in_valid  = 1'b1;
        out_ready = 1'b0;
        #1;
        chk("R11 ready low", {30'b0, in_ready, out_valid}, 32'b01);
        @(negedge clk);
        #1;
        chk("R11 held in header", {31'b0, out_is_hdr}, 32'd1);
        present(32'h1010_0002);
        present(32'hCAFE_0000);
        chk("R11 payload after stall", {19'b0, out_offset, out_wen}, {19'b0, 12'h010, 1'b1});
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        chk("R11 valid follows", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        #1;
        chk("R11 held mid command", {19'b0, out_is_hdr, out_offset}, {19'b0, 1'b0, 12'h011});

        // R12 reset mid command
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_word  = 32'h4000_0000;
        in_valid = 1'b0;
        #1;
        chk("R12 hdr after mid reset", {31'b0, out_is_hdr}, 32'd1);
        chk("R12 class cleared", {22'b0, out_class}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule